// File: doc/BRIEF.md
# Watchdog Guard Timer

The block guards a device against software that has stopped running. A free-running tick is divided by a programmable power of two. Each time that division completes, an event counter advances. If software lets the event counter run past its top value, the block fires a one-cycle reset pulse. Software prevents this by issuing a kick command at regular intervals. A kick empties both the divider and the event counter.

Two sticky status flags tell software why the device last started. The "no timeout" flag drops when the guard fires. The "awake" flag drops when the device is put to sleep. A kick or a power-on reset raises both flags. A sleep command marks the device as sleeping and also records that no timeout has occurred. An enable input freezes the whole timing chain without disturbing the flags.

Top module: `wdog_guard`

## Requirements
- R1: While rst_n is low and on the first cycle after it rises, bite_o is 0, no_tmo_o is 1, awake_o is 1, and the divider and event counter are both zero.
- R2: With run_en_i high and div_sel_i = N, the event counter advances once for every 2^N cycles in which tick_i is high. Cycles with tick_i low do not count.
- R3: An advance taken while the event counter is at all ones wraps the counter to zero. In the cycle after that clock edge, bite_o is 1 for exactly one cycle. After a kick, with tick_i high every cycle, bite_o first reads 1 on the (2^CNT_W · 2^N)-th cycle.
- R4: The edge that raises bite_o also sets no_tmo_o to 0.
- R5: kick_i clears the divider and the event counter. The full period of R3 restarts from the kick edge.
- R6: kick_i sets no_tmo_o and awake_o to 1 at the next edge.
- R7: A kick in the same cycle as an overflowing advance wins. bite_o stays 0 and no_tmo_o stays 1.
- R8: doze_i without kick_i sets awake_o to 0. It also sets no_tmo_o to 1, unless an overflow occurs in that same cycle, in which case no_tmo_o goes to 0.
- R9: While run_en_i is 0, ticks are ignored: the divider and event counter hold and bite_o stays 0. When run_en_i returns to 1, counting resumes from the held values.
- R10: The divider completes on any tick where its count is at or above 2^N−1 for the current N. Lowering N mid-count therefore advances the counter on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| tick_i | input | 1 | Free-running time-base tick, one cycle per pulse |
| run_en_i | input | 1 | Enables the divider and event counter |
| div_sel_i | input | SEL_W | Divider exponent N (divide by 2^N) |
| kick_i | input | 1 | Clear command from software |
| doze_i | input | 1 | Sleep command |
| bite_o | output | 1 | One-cycle device reset pulse |
| no_tmo_o | output | 1 | Status: 1 = no timeout since last kick, sleep or reset |
| awake_o | output | 1 | Status: 0 = sleep command seen since last kick or reset |

## Verification
The bench builds the guard with CNT_W = 4 and SEL_W = 3. This gives a 16-step event counter and divider exponents 0 to 7. The longest period is then 2048 ticks, and the slowest divider setting can be driven to an overflow within a short run. The same settings keep random kicks sparse enough that overflows also occur under random stimulus. They also allow a directed case that lowers the exponent after the divider has already passed the new limit, and one that lands a kick exactly on the overflowing tick.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef struct packed {
    logic no_tmo;
    logic awake;
  } wdog_flags_t;

  // divider terminal value for exponent sel: 2^sel - 1
  function automatic int unsigned div_limit(int unsigned sel);
    return (32'd1 << sel) - 32'd1;
  endfunction

  // divider completes once the count has reached the terminal value
  function automatic logic div_done(int unsigned cur, int unsigned lim);
    return cur >= lim;
  endfunction

  // next status flags, priority kick > overflow > sleep
  function automatic wdog_flags_t flags_next(wdog_flags_t cur, logic kick,
                                             logic ovf, logic doze);
    wdog_flags_t nx;
    nx = cur;
    if (kick) begin
      nx.no_tmo = 1'b1;
      nx.awake  = 1'b1;
    end else begin
      if (doze) begin
        nx.awake  = 1'b0;
        nx.no_tmo = 1'b1;
      end
      if (ovf) nx.no_tmo = 1'b0;
    end
    return nx;
  endfunction

endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int SEL_W = 4,
  parameter int PRE_W = (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             term_o,
  output logic [PRE_W-1:0] pre_q_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] lim;

  assign lim     = PRE_W'(wdog_pkg::div_limit(32'(sel_i)));
  assign term_o  = step_i && wdog_pkg::div_done(32'(pre_q), 32'(lim));
  assign pre_q_o = pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pre_q <= '0;
    else if (clr_i)   pre_q <= '0;
    else if (term_o)  pre_q <= '0;
    else if (step_i)  pre_q <= pre_q + PRE_W'(1);
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             adv_i,
  output logic             ovf_o,
  output logic [CNT_W-1:0] cnt_q_o
);
  logic [CNT_W-1:0] cnt_q;

  assign ovf_o   = adv_i && !clr_i && (&cnt_q);
  assign cnt_q_o = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (adv_i)  cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/wdog_flags.sv
module wdog_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_i,
  input  logic doze_i,
  input  logic ovf_i,
  output logic bite_o,
  output logic no_tmo_o,
  output logic awake_o
);
  wdog_pkg::wdog_flags_t flg_q, flg_d;
  logic bite_q;

  always_comb flg_d = wdog_pkg::flags_next(flg_q, kick_i, ovf_i, doze_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q  <= '{no_tmo: 1'b1, awake: 1'b1};
      bite_q <= 1'b0;
    end else begin
      flg_q  <= flg_d;
      bite_q <= ovf_i && !kick_i;
    end
  end

  assign bite_o   = bite_q;
  assign no_tmo_o = flg_q.no_tmo;
  assign awake_o  = flg_q.awake;
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard #(
  parameter int CNT_W = 8,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             run_en_i,
  input  logic [SEL_W-1:0] div_sel_i,
  input  logic             kick_i,
  input  logic             doze_i,
  output logic             bite_o,
  output logic             no_tmo_o,
  output logic             awake_o
);
  localparam int PRE_W = (1 << SEL_W) - 1;

  logic             div_step;
  logic             pre_term;
  logic             ovf_evt;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;

  assign div_step = run_en_i && tick_i;

  wdog_prescale #(.SEL_W(SEL_W), .PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (kick_i),
    .step_i  (div_step),
    .sel_i   (div_sel_i),
    .term_o  (pre_term),
    .pre_q_o (pre_q)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (kick_i),
    .adv_i   (pre_term),
    .ovf_o   (ovf_evt),
    .cnt_q_o (cnt_q)
  );

  wdog_flags u_flg (
    .clk      (clk),
    .rst_n    (rst_n),
    .kick_i   (kick_i),
    .doze_i   (doze_i),
    .ovf_i    (ovf_evt),
    .bite_o   (bite_o),
    .no_tmo_o (no_tmo_o),
    .awake_o  (awake_o)
  );
endmodule

// File: rtl/wdog_guard_chk.sv
module wdog_guard_chk #(
  parameter int CNT_W = 8,
  parameter int PRE_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             kick_i,
  input logic             doze_i,
  input logic             run_en_i,
  input logic             bite_o,
  input logic             no_tmo_o,
  input logic             awake_o,
  input logic             ovf_evt,
  input logic             pre_term,
  input logic [CNT_W-1:0] cnt_q,
  input logic [PRE_W-1:0] pre_q
);
  p_bite_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bite_o |=> !bite_o);

  p_bite_from_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bite_o |-> $past(ovf_evt));

  p_bite_drops_tmo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bite_o |-> !no_tmo_o);

  p_kick_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    kick_i |=> (cnt_q == '0) && (pre_q == '0));

  p_kick_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    kick_i |=> no_tmo_o && awake_o);

  p_kick_beats_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    kick_i |=> !bite_o);

  p_doze_sleeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (doze_i && !kick_i) |=> !awake_o);

  p_hold_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en_i && !kick_i) |=> $stable(cnt_q) && $stable(pre_q));

  p_term_restarts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pre_term |=> (pre_q == '0));
endmodule

bind wdog_guard wdog_guard_chk #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .kick_i   (kick_i),
  .doze_i   (doze_i),
  .run_en_i (run_en_i),
  .bite_o   (bite_o),
  .no_tmo_o (no_tmo_o),
  .awake_o  (awake_o),
  .ovf_evt  (ovf_evt),
  .pre_term (pre_term),
  .cnt_q    (cnt_q),
  .pre_q    (pre_q)
);

// File: tb/wdog_guard_test.sv
module wdog_guard_test;
  localparam int CW   = 4;
  localparam int SW   = 3;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, en = 1'b0, kick = 1'b0, doze = 1'b0;
  logic [SW-1:0] sel = '0;
  logic bite, no_tmo, awake;

  int checks = 0;
  int fails = 0;
  string phase = "R1";

  int m_cnt = 0, m_pre = 0;
  bit m_to = 1'b1, m_pd = 1'b1, m_bite = 1'b0;

  always #4 clk = ~clk;

  wdog_guard #(.CNT_W(CW), .SEL_W(SW)) uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .run_en_i(en),
    .div_sel_i(sel), .kick_i(kick), .doze_i(doze),
    .bite_o(bite), .no_tmo_o(no_tmo), .awake_o(awake)
  );

  function automatic int period_of(int n);
    return (CMAX + 1) * (1 << n);
  endfunction

  // reference: behaviour after one edge, from the requirement list
  task automatic model_step();
    bit wrap;
    if (!rst_n) begin
      m_cnt = 0; m_pre = 0; m_to = 1; m_pd = 1; m_bite = 0;
      return;
    end
    wrap = 0;
    if (kick) begin
      m_cnt = 0; m_pre = 0; m_to = 1; m_pd = 1;
    end else begin
      if (en && tick) begin
        if (m_pre + 1 >= (1 << int'(sel))) begin
          m_pre = 0;
          if (m_cnt == CMAX) begin
            wrap = 1; m_cnt = 0;
          end else m_cnt++;
        end else m_pre++;
      end
      if (doze) begin m_pd = 0; m_to = 1; end
      if (wrap) m_to = 0;
    end
    m_bite = wrap;
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    model_step();
    check({bite, no_tmo, awake} == {m_bite, m_to, m_pd}, phase,
          int'({bite, no_tmo, awake}), int'({m_bite, m_to, m_pd}));
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // kick, then count cycles to the first bite
  task automatic time_bite(output int k);
    k = 0;
    do begin
      step();
      k++;
    end while (!bite && k < 5000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    int k;
    bit seen;
    void'($urandom(32'd1946));
    // R1 reset state
    repeat (3) step();
    check(bite == 0 && no_tmo == 1 && awake == 1, "R1", int'({bite, no_tmo, awake}), 3);
    rst_n = 1'b1;
    step();
    check(bite == 0 && no_tmo == 1 && awake == 1, "R1", int'({bite, no_tmo, awake}), 3);

    // R2 R3 R4 R5: full period from a kick for several exponents
    foreach (phase[i]) ;
    for (int n = 0; n < 8; n += 3) begin
      phase = "R2";
      sel = SW'(n); en = 1; tick = 1; kick = 1;
      step();
      kick = 0;
      time_bite(k);
      check(k == period_of(n), "R5 period", k, period_of(n));
      check(no_tmo == 0, "R4", int'(no_tmo), 0);
      phase = "R3";
      step();
      check(bite == 0, "R3 single pulse", int'(bite), 0);
    end

    // R2: ticks low do not count
    phase = "R2";
    sel = 1; kick = 1; step(); kick = 0;
    for (int i = 0; i < 20; i++) begin tick = (i % 2); step(); end
    tick = 1;
    time_bite(k);
    check(k == period_of(1) - 10, "R2 gaps", k, period_of(1) - 10);

    // R7: kick on the overflowing tick
    phase = "R7";
    sel = 0; kick = 1; step(); kick = 0;
    repeat (CMAX) step();
    kick = 1; step(); kick = 0;
    check(bite == 0 && no_tmo == 1, "R7", int'({bite, no_tmo}), 1);

    // R9: disabled chain ignores ticks then resumes
    phase = "R9";
    sel = 1; kick = 1; step(); kick = 0;
    repeat (5) step();
    en = 0; seen = 0;
    for (int i = 0; i < 60; i++) begin step(); if (bite) seen = 1; end
    check(!seen, "R9 no bite while off", int'(seen), 0);
    en = 1;
    time_bite(k);
    check(k == period_of(1) - 5, "R9 resume", k, period_of(1) - 5);

    // R8: sleep, and kick overriding sleep
    phase = "R8";
    doze = 1; step(); doze = 0;
    check(awake == 0 && no_tmo == 1, "R8 sleep", int'({no_tmo, awake}), 2);
    doze = 1; kick = 1; step(); doze = 0; kick = 0;
    check(awake == 1 && no_tmo == 1, "R8 kick wins", int'({no_tmo, awake}), 3);

    // R10: lower the exponent after the divider passed the new limit
    phase = "R10";
    sel = 3; kick = 1; step(); kick = 0;
    repeat (5) step();
    sel = 1;
    step();
    time_bite(k);
    check(k == CMAX * 2, "R10", k, CMAX * 2);

    // random mix, every cycle checked against the reference
    phase = "R2 R3 R4 R6 R8 R9 random";
    for (int i = 0; i < 4000; i++) begin
      tick = ($urandom_range(0, 3) != 0);
      en   = ($urandom_range(0, 19) != 0);
      kick = ($urandom_range(0, 299) == 0);
      doze = ($urandom_range(0, 99) == 0);
      if ($urandom_range(0, 199) == 0) sel = SW'($urandom_range(0, 2));
      step();
    end
    kick = 0; doze = 0;
    step();

    summary();
    $finish;
  end
endmodule